// File: doc/BRIEF.md
# LCD Sync Delay and Polarity Shaper

This block sits between an LCD timing generator and the panel pins. It takes the generator's raw pixel clock, horizontal sync, vertical sync and line-load signals and turns them into the panel's outputs. The horizontal sync can be moved later by a programmed number of pixel-clock pulses. The vertical sync is stretched to a programmed count of horizontal-sync periods. Each of the four outputs has its own polarity select. All inputs are sampled as levels in the fast system clock domain. A pixel-clock pulse is a rising edge of `pclk_raw` seen by that clock.

Software sets the block up through a write-only port that holds two byte-wide registers: a delay register and a control register. A write goes into a staging copy. The staged values become active at the start of the next frame, which is the cycle in which a rising edge of `vsync_ref` is seen. A frame that is already running therefore never changes shape part-way through. The generator's timing itself comes from outside the block.

Top module: `lcd_sync_shaper`

## Requirements
- R1: With delay value d (1..127), `hsync_ref` is sampled on every pixel-clock rising edge. Between one pixel-clock rising edge and the next, the delayed sync holds the sample taken d pixel-clock edges earlier.
- R2: With delay value 0, the delayed sync follows `hsync_ref` directly, with the same single cycle of latency as the other outputs.
- R3: The delayed horizontal sync pulse keeps the width of the reference pulse, measured in pixel-clock edges.
- R4: The vertical sync is asserted from the frame-start cycle. It ends after a selected number N of `hsync_ref` rising edges seen after the start: width code 00 gives N=1, 01 gives N=2 and 10 gives N=3. The output drops one cycle after the cycle in which the N-th edge is seen. An edge in the start cycle itself is not counted.
- R5: Width code 11 behaves exactly like code 10 (three periods).
- R6: The control register carries four polarity bits: bit 7 for the pixel clock, bit 6 for the horizontal sync, bit 5 for the vertical sync and bit 4 for line load. A bit value of 1 inverts its output and 0 passes it unchanged.
- R7: After reset the delay is 0 and the control value is 0x20, with the vertical-sync polarity set and everything else clear. The idle outputs are therefore `pclk_o`=0, `hsync_o`=0, `vsync_o`=1 and `lload_o`=0.
- R8: Writes only update staging copies. The delay, width and polarity in use change in the frame-start cycle and at no other time.
- R9: Every output is registered once after its polarity XOR, so each output trails its input by exactly one clock.
- R10: Bit 7 of the delay register and bits 3:2 of the control register are ignored. `wr_sel`=0 selects the delay register and 1 selects the control register.
- R11: Only the rising edge of `vsync_ref` starts a frame, so how long `vsync_ref` stays high has no effect. A new rising edge during a stretched pulse restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = delay register, 1 = control register |
| wr_data | input | 8 | Register write data |
| pclk_raw | input | 1 | Raw pixel clock from the timing generator |
| hsync_ref | input | 1 | Reference horizontal sync (zero delay) |
| vsync_ref | input | 1 | Reference vertical sync |
| lload_ref | input | 1 | Reference line-load strobe |
| pclk_o | output | 1 | Pixel clock after polarity select |
| hsync_o | output | 1 | Delayed horizontal sync after polarity select |
| vsync_o | output | 1 | Stretched vertical sync after polarity select |
| lload_o | output | 1 | Line load after polarity select |

## Verification
The hardest case to reach is a register write that lands inside a running frame. It must have no effect until the next vertical-sync rising edge, and then take effect together with the width and delay changes in that same cycle. The bench writes new delay, width and polarity values between horizontal pulses while a frame is running, and keeps stepping pixels and checking every output. Only after that does it raise `vsync_ref`. A second hard case is the deepest delay, 127 pixel clocks. To reach it the bench drives a long run of pixel steps, and it keeps a log of every sampled horizontal-sync value so that it can predict the output at any tap.

// File: rtl/lcd_shp_pkg.sv
package lcd_shp_pkg;

    typedef enum logic {
        SEL_DELAY = 1'b0,
        SEL_CTRL  = 1'b1
    } shp_sel_e;

    typedef struct packed {
        logic       pol_pclk;
        logic       pol_hs;
        logic       pol_vs;
        logic       pol_ll;
        logic [1:0] vs_width;
    } shp_ctl_t;

    localparam int BIT_POL_PCLK = 7;
    localparam int BIT_POL_HS   = 6;
    localparam int BIT_POL_VS   = 5;
    localparam int BIT_POL_LL   = 4;
    localparam int BIT_WID_HI   = 1;
    localparam int BIT_WID_LO   = 0;

    localparam shp_ctl_t CTL_RST = '{pol_pclk: 1'b0, pol_hs: 1'b0, pol_vs: 1'b1,
                                     pol_ll: 1'b0, vs_width: 2'b00};

    // number of horizontal periods that a width code selects; code 11 acts as 10
    function automatic logic [1:0] vs_lines(input logic [1:0] code);
        return (code == 2'b11) ? 2'd3 : 2'(code + 2'd1);
    endfunction

endpackage

// File: rtl/lcd_shp_cfg.sv
module lcd_shp_cfg
    import lcd_shp_pkg::*;
#(
    parameter int DLY_W = 7,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             frame_start,
    output logic [DLY_W-1:0] dly_eff,
    output shp_ctl_t         ctl_eff,
    output shp_ctl_t         ctl_act
);

    typedef struct packed {
        logic [DLY_W-1:0] stg_dly;
        shp_ctl_t         stg_ctl;
        logic [DLY_W-1:0] act_dly;
        shp_ctl_t         act_ctl;
    } cfg_st_t;

    localparam cfg_st_t ST_RST = '{stg_dly: '0, stg_ctl: CTL_RST,
                                   act_dly: '0, act_ctl: CTL_RST};

    cfg_st_t  st_d, st_q;
    shp_ctl_t ctl_wr;
    logic     rsvd_unused;

    assign rsvd_unused = ^wr_data[BIT_POL_LL-1:BIT_WID_HI+1];

    always_comb begin
        ctl_wr.pol_pclk = wr_data[BIT_POL_PCLK];
        ctl_wr.pol_hs   = wr_data[BIT_POL_HS];
        ctl_wr.pol_vs   = wr_data[BIT_POL_VS];
        ctl_wr.pol_ll   = wr_data[BIT_POL_LL];
        ctl_wr.vs_width = wr_data[BIT_WID_HI:BIT_WID_LO];

        st_d = st_q;
        if (wr_en) begin
            case (shp_sel_e'(wr_sel))
                SEL_DELAY: st_d.stg_dly = wr_data[DLY_W-1:0];
                SEL_CTRL:  st_d.stg_ctl = ctl_wr;
                default:   st_d.stg_dly = st_q.stg_dly;
            endcase
        end
        if (frame_start) begin
            st_d.act_dly = st_q.stg_dly;
            st_d.act_ctl = st_q.stg_ctl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    // the frame-start cycle already runs with the staged settings
    assign dly_eff = frame_start ? st_q.stg_dly : st_q.act_dly;
    assign ctl_eff = frame_start ? st_q.stg_ctl : st_q.act_ctl;
    assign ctl_act = st_q.act_ctl;

endmodule

// File: rtl/lcd_shp_hdly.sv
module lcd_shp_hdly #(
    parameter int DLY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pclk_raw,
    input  logic             hs_ref,
    input  logic [DLY_W-1:0] dly,
    output logic             hs_dly
);

    localparam int DEPTH = (1 << DLY_W) - 1;

    typedef struct packed {
        logic [DEPTH-1:0] hist;
        logic             held;
        logic             pclk_prev;
    } hd_st_t;

    hd_st_t st_d, st_q;
    logic   tick;
    logic   tap;

    always_comb begin
        tick = pclk_raw & ~st_q.pclk_prev;

        tap = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (dly == DLY_W'(i + 1)) tap = st_q.hist[i];
        end

        st_d           = st_q;
        st_d.pclk_prev = pclk_raw;
        if (tick) begin
            st_d.hist[0] = hs_ref;
            for (int i = 1; i < DEPTH; i++) st_d.hist[i] = st_q.hist[i-1];
            st_d.held = tap;
        end

        if (dly == '0)  hs_dly = hs_ref;
        else if (tick)  hs_dly = tap;
        else            hs_dly = st_q.held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lcd_shp_vstr.sv
module lcd_shp_vstr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_ref,
    input  logic             hs_ref,
    input  logic [CNT_W-1:0] lines,
    output logic             frame_start,
    output logic             hs_edge,
    output logic             vs_str
);

    typedef struct packed {
        logic             vs_prev;
        logic             hs_prev;
        logic             active;
        logic [CNT_W-1:0] cnt;
    } vs_st_t;

    vs_st_t st_d, st_q;

    always_comb begin
        frame_start = vs_ref & ~st_q.vs_prev;
        hs_edge     = hs_ref & ~st_q.hs_prev;

        st_d         = st_q;
        st_d.vs_prev = vs_ref;
        st_d.hs_prev = hs_ref;
        if (frame_start) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && hs_edge) begin
            if (st_q.cnt == CNT_W'(lines - 1'b1)) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        vs_str = frame_start | st_q.active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/lcd_shp_out.sv
module lcd_shp_out #(
    parameter int         NSIG    = 4,
    parameter logic [3:0] RST_VAL = 4'b0010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSIG-1:0] raw,
    input  logic [NSIG-1:0] pol,
    output logic [NSIG-1:0] sig_o
);

    logic [NSIG-1:0] lane_d, lane_q;

    for (genvar g = 0; g < NSIG; g++) begin : g_lane
        always_comb lane_d[g] = raw[g] ^ pol[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= RST_VAL[NSIG-1:0];
        else        lane_q <= lane_d;
    end

    assign sig_o = lane_q;

endmodule

// File: rtl/lcd_sync_shaper.sv
module lcd_sync_shaper
    import lcd_shp_pkg::*;
#(
    parameter int DLY_W = 7,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             pclk_raw,
    input  logic             hsync_ref,
    input  logic             vsync_ref,
    input  logic             lload_ref,
    output logic             pclk_o,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             lload_o
);

    localparam int         NSIG    = 4;
    localparam int         CNT_W   = 2;
    localparam logic [3:0] OUT_RST = {CTL_RST.pol_pclk, CTL_RST.pol_hs,
                                      CTL_RST.pol_vs, CTL_RST.pol_ll};

    logic [DLY_W-1:0] dly_eff;
    shp_ctl_t         ctl_eff;
    shp_ctl_t         ctl_act;
    logic             frame_start;
    logic             hs_edge;
    logic             vs_str;
    logic             hs_dly;
    logic [CNT_W-1:0] lines;
    logic [NSIG-1:0]  raw_vec;
    logic [NSIG-1:0]  pol_eff;
    logic [NSIG-1:0]  out_vec;

    assign lines = vs_lines(ctl_eff.vs_width);

    lcd_shp_cfg #(.DLY_W(DLY_W), .REG_W(REG_W)) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .dly_eff     (dly_eff),
        .ctl_eff     (ctl_eff),
        .ctl_act     (ctl_act)
    );

    lcd_shp_vstr #(.CNT_W(CNT_W)) i_vstr (
        .clk         (clk),
        .rst_n       (rst_n),
        .vs_ref      (vsync_ref),
        .hs_ref      (hsync_ref),
        .lines       (lines),
        .frame_start (frame_start),
        .hs_edge     (hs_edge),
        .vs_str      (vs_str)
    );

    lcd_shp_hdly #(.DLY_W(DLY_W)) i_hdly (
        .clk      (clk),
        .rst_n    (rst_n),
        .pclk_raw (pclk_raw),
        .hs_ref   (hsync_ref),
        .dly      (dly_eff),
        .hs_dly   (hs_dly)
    );

    assign raw_vec = {pclk_raw, hs_dly, vs_str, lload_ref};
    assign pol_eff = {ctl_eff.pol_pclk, ctl_eff.pol_hs, ctl_eff.pol_vs, ctl_eff.pol_ll};

    lcd_shp_out #(.NSIG(NSIG), .RST_VAL(OUT_RST)) i_out (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_vec),
        .pol   (pol_eff),
        .sig_o (out_vec)
    );

    assign pclk_o  = out_vec[3];
    assign hsync_o = out_vec[2];
    assign vsync_o = out_vec[1];
    assign lload_o = out_vec[0];

endmodule

// File: rtl/lcd_sync_shaper_chk.sv
module lcd_sync_shaper_chk
    import lcd_shp_pkg::*;
#(
    parameter int DLY_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pclk_raw,
    input logic             hsync_ref,
    input logic             lload_ref,
    input logic             pclk_o,
    input logic             hsync_o,
    input logic             vsync_o,
    input logic             lload_o,
    input logic             frame_start,
    input logic             hs_edge,
    input logic             vs_str,
    input logic [DLY_W-1:0] dly_eff,
    input logic [3:0]       pol_eff,
    input shp_ctl_t         ctl_act
);

    AST_PCLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pclk_o == ($past(pclk_raw) ^ $past(pol_eff[3]))); // R9

    AST_LLOAD_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> lload_o == ($past(lload_ref) ^ $past(pol_eff[0]))); // R6

    AST_ZERO_DELAY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dly_eff) == '0) |-> hsync_o == ($past(hsync_ref) ^ $past(pol_eff[2]))); // R2

    AST_VS_OPENS_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(frame_start)) |-> vsync_o == !$past(pol_eff[1])); // R11

    AST_VS_CLOSES_ON_HS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vs_str) && !vs_str) |-> $past(hs_edge)); // R4

    AST_CFG_FROZEN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(frame_start)) |-> $stable(ctl_act)); // R8

endmodule

bind lcd_sync_shaper lcd_sync_shaper_chk #(.DLY_W(DLY_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pclk_raw    (pclk_raw),
    .hsync_ref   (hsync_ref),
    .lload_ref   (lload_ref),
    .pclk_o      (pclk_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .lload_o     (lload_o),
    .frame_start (frame_start),
    .hs_edge     (hs_edge),
    .vs_str      (vs_str),
    .dly_eff     (dly_eff),
    .pol_eff     (pol_eff),
    .ctl_act     (ctl_act)
);

// File: tb/test_lcd_sync_shaper.sv
module test_lcd_sync_shaper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pclk_raw = 1'b0;
    logic       hsync_ref = 1'b0;
    logic       vsync_ref = 1'b0;
    logic       lload_ref = 1'b0;
    logic       pclk_o, hsync_o, vsync_o, lload_o;

    always #2 clk = ~clk;

    lcd_sync_shaper i_lcd_sync_shaper (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pclk_raw(pclk_raw), .hsync_ref(hsync_ref), .vsync_ref(vsync_ref),
        .lload_ref(lload_ref), .pclk_o(pclk_o), .hsync_o(hsync_o),
        .vsync_o(vsync_o), .lload_o(lload_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    string scen = "R7";

    // reference model, from the requirements
    logic [6:0] stg_dly = '0, act_dly = '0;
    logic [7:0] stg_ctl = 8'h20, act_ctl = 8'h20;
    logic       m_act = 1'b0, m_vs_prev = 1'b0, m_hs_prev = 1'b0;
    int         m_cnt = 0;
    int         nstep = 0;
    logic       hs_log [0:4095];

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b (step %0d)", req, what, act, exp, nstep);
        end
    endtask

    function automatic int lines_of(input logic [1:0] code);
        return (code == 2'b11) ? 3 : int'(code) + 1;
    endfunction

    task automatic wr(input logic sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (sel) stg_ctl = data;
        else     stg_dly = data[6:0];
    endtask

    // one pixel period: a cycle with pclk high, then one with pclk low
    task automatic pstep(input logic hs, input logic vs, input logic ll);
        logic e_hs;
        hs_log[nstep] = hs;
        if (vs && !m_vs_prev) begin
            act_dly = stg_dly; act_ctl = stg_ctl; m_act = 1'b1; m_cnt = 0;
        end else if (m_act && hs && !m_hs_prev) begin
            if (m_cnt == lines_of(act_ctl[1:0]) - 1) begin m_act = 1'b0; m_cnt = 0; end
            else m_cnt++;
        end
        m_vs_prev = vs; m_hs_prev = hs;
        pclk_raw = 1'b1; hsync_ref = hs; vsync_ref = vs; lload_ref = ll;
        @(posedge clk); #1;
        chk("R9", "pclk_o high phase", pclk_o, 1'b1 ^ act_ctl[7]);
        pclk_raw = 1'b0;
        @(posedge clk); #1;
        if (act_dly == 0) e_hs = hs;
        else e_hs = (nstep >= int'(act_dly)) ? hs_log[nstep - int'(act_dly)] : 1'b0;
        chk("R9", "pclk_o low phase", pclk_o, act_ctl[7]);
        chk(scen, "hsync_o", hsync_o, e_hs ^ act_ctl[6]);
        chk(scen, "vsync_o", vsync_o, m_act ^ act_ctl[5]);
        chk(scen, "lload_o", lload_o, ll ^ act_ctl[4]);
        nstep++;
    endtask

    task automatic load_frame;
        pstep(1'b0, 1'b1, 1'b0);
        pstep(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_reset;
        scen = "R7";
        chk("R7", "pclk_o in reset", pclk_o, 1'b0);
        chk("R7", "hsync_o in reset", hsync_o, 1'b0);
        chk("R7", "vsync_o in reset", vsync_o, 1'b1);
        chk("R7", "lload_o in reset", lload_o, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R7", "vsync_o idle", vsync_o, 1'b1);
        chk("R7", "hsync_o idle", hsync_o, 1'b0);
        pstep(1'b1, 1'b0, 1'b1);
        pstep(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_delay(input logic [7:0] d, input int w, input string tag);
        scen = tag;
        wr(1'b0, d);
        wr(1'b1, 8'h00);
        load_frame();
        for (int i = 0; i < w; i++) pstep(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < int'(d[6:0]) + w + 3; i++) pstep(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_width(input logic [1:0] code, input string tag);
        scen = tag;
        wr(1'b1, {6'b001000, code});
        pstep(1'b0, 1'b1, 1'b0);
        // vsync_ref stays high a while: only its rising edge counts (R11)
        pstep(1'b0, 1'b1, 1'b0);
        pstep(1'b0, 1'b1, 1'b0);
        for (int p = 0; p < 4; p++) begin
            pstep(1'b1, 1'b0, 1'b0);
            pstep(1'b0, 1'b0, 1'b0);
            pstep(1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_restart;
        scen = "R11";
        wr(1'b1, 8'h21);
        pstep(1'b0, 1'b1, 1'b0);
        pstep(1'b0, 1'b0, 1'b0);
        pstep(1'b1, 1'b0, 1'b0);
        pstep(1'b0, 1'b0, 1'b0);
        pstep(1'b0, 1'b1, 1'b0);
        for (int p = 0; p < 3; p++) begin
            pstep(1'b1, 1'b0, 1'b0);
            pstep(1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_polarity;
        scen = "R6";
        wr(1'b0, 8'h02);
        wr(1'b1, 8'hF0);
        load_frame();
        pstep(1'b1, 1'b0, 1'b1);
        pstep(1'b1, 1'b0, 1'b0);
        pstep(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) pstep(1'b0, 1'b0, 1'b0);
        wr(1'b1, 8'h50);
        load_frame();
        pstep(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) pstep(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_shadow;
        scen = "R8";
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h20);
        load_frame();
        wr(1'b0, 8'h09);
        wr(1'b1, 8'hD2);
        for (int p = 0; p < 3; p++) begin
            pstep(1'b1, 1'b0, 1'b1);
            pstep(1'b0, 1'b0, 1'b0);
            pstep(1'b0, 1'b0, 1'b1);
        end
        chk("R8", "delay still zero", hsync_o, 1'b0);
        load_frame();
        pstep(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 14; i++) pstep(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_ignored;
        scen = "R10";
        wr(1'b0, 8'h84);
        wr(1'b1, 8'h2D);
        load_frame();
        pstep(1'b1, 1'b0, 1'b0);
        pstep(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) pstep(1'b0, 1'b0, 1'b0);
        for (int p = 0; p < 3; p++) begin
            pstep(1'b1, 1'b0, 1'b0);
            pstep(1'b0, 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_delay(8'd0, 3, "R2");
        t_delay(8'd1, 2, "R1 R3");
        t_delay(8'd5, 4, "R1 R3");
        t_delay(8'd127, 3, "R1 R3");
        t_width(2'b00, "R4");
        t_width(2'b01, "R4");
        t_width(2'b10, "R4");
        t_width(2'b11, "R5");
        t_restart();
        t_polarity();
        t_shadow();
        t_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule